// File: doc/BRIEF.md
# Interrupt-Driven Transfer Channel Engine

This engine answers interrupt requests by copying a single data item instead of running a service routine. Eight channels share one sequencer. Each channel holds a source pointer, a destination pointer, a transfer counter and a small control field. A request on a channel makes the engine read one byte or one 16-bit word from the source address and write it to the destination address. It then moves the pointers forward and lowers the counter. The processor loses only the bus cycles of that one copy and never branches to a vector.

When a request finds its channel's counter at zero, no copy takes place. The engine instead sends a one-cycle pulse on that channel's completion output, which the interrupt controller turns into a normal interrupt. A channel in continuous mode never counts down and never produces that pulse. The engine takes the memory bus from the processor through a stall/grant pair. A register port lets software set up each channel and read it back.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset all channel fields read zero, no request is pending, and `cpu_stall_o`, `mem_rd_o`, `mem_wr_o` and `irq_o` are low.
- R2: The register port addresses channel `reg_ch_i` and field `reg_fld_i`: 0 source pointer, 1 destination pointer, 2 counter (low CW bits), 3 control (low 4 bits). A write takes effect at the clock edge. `reg_rdata_o` shows the addressed field, zero-extended, in the same cycle.
- R3: The control field bits are: bit 0 selects word size (1) or byte size (0); bit 1 advances the source pointer; bit 2 advances the destination pointer; bit 3 selects continuous mode.
- R4: A service reads once from the source pointer and then writes once to the destination pointer. `mem_word_o` shows the size. In byte mode the written value is the low byte of the read data, zero-extended.
- R5: After each copy the selected pointers advance by 1 in byte mode and by 2 in word mode. Pointers whose advance bit is clear stay as they are.
- R6: The counter drops by one on each copy when the channel is not in continuous mode. In continuous mode it is left unchanged.
- R7: A request on a channel that is not in continuous mode and whose counter is zero causes no bus access. It raises `irq_o` for that channel alone, for exactly one cycle, and leaves the pointers unchanged.
- R8: When several requests are pending, the lowest channel number is served first. Each service finishes before the next one begins.
- R9: `cpu_stall_o` rises once a copy is accepted. The read starts only after `bus_grant_i` has been seen high. Stall stays high through the cycle in which the write is accepted and is low in the cycle after.
- R10: A new request on a channel that arrives in the same cycle as that channel's copy completes stays pending and produces a second service.
- R11: A register write to a field in the same cycle as the engine updates that field after a copy takes precedence. The other fields still take the engine's update.
- R12: While `mem_ready_i` is low, the active read or write and its address are held unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCH | Per-channel service requests from the interrupt controller |
| reg_we_i | input | 1 | Register write strobe |
| reg_ch_i | input | CHW | Channel addressed by the register port |
| reg_fld_i | input | 2 | Field select: 0 source, 1 destination, 2 counter, 3 control |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Addressed field, zero-extended |
| cpu_stall_o | output | 1 | Asks the processor to give up the bus |
| bus_grant_i | input | 1 | Processor has released the bus |
| mem_rd_o | output | 1 | Read phase active |
| mem_wr_o | output | 1 | Write phase active |
| mem_word_o | output | 1 | Access size: 1 word, 0 byte |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data |
| mem_ready_i | input | 1 | Current phase completes at this edge |
| irq_o | output | NCH | One-cycle pulse asking for a normal interrupt on that channel |

## Verification
Two things can land in the same clock edge: a channel's copy completing and a new event on that same channel. The new event can be a fresh request or a software write to the source pointer. The bench watches for the cycle in which the write phase sees ready high, and drives the new event in exactly that cycle. For a fresh request, the scoreboard must then see a second copy using the advanced pointers. For a register write, the source pointer must read back the written value while the destination pointer shows the engine's advance.

// File: rtl/ixe_pkg.sv
package ixe_pkg;

    typedef enum logic [1:0] {
        FLD_SRC = 2'd0,
        FLD_DST = 2'd1,
        FLD_CNT = 2'd2,
        FLD_CTL = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } seq_st_e;

    // bit 3 continuous, bit 2 dst advance, bit 1 src advance, bit 0 word size
    typedef struct packed {
        logic cont;
        logic dst_inc;
        logic src_inc;
        logic word;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/ixe_pick.sv
module ixe_pick #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] pend_i,
    output logic           valid_o,
    output logic [CHW-1:0] idx_o
);

    // Lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        valid_o = |pend_i;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = CHW'(i);
            end
        end
    end

endmodule

// File: rtl/ixe_chan_bank.sv
module ixe_chan_bank
    import ixe_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [CHW-1:0] wr_ch_i,
    input  fld_e           wr_fld_i,
    input  logic [AW-1:0]  wr_data_i,
    input  logic           upd_en_i,
    input  logic [CHW-1:0] upd_ch_i,
    input  logic [AW-1:0]  upd_src_i,
    input  logic [AW-1:0]  upd_dst_i,
    input  logic [CW-1:0]  upd_cnt_i,
    output logic [AW-1:0]  src_o [NCH],
    output logic [AW-1:0]  dst_o [NCH],
    output logic [CW-1:0]  cnt_o [NCH],
    output ctl_t           ctl_o [NCH]
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        ctl_t          ctl;
    } chan_t;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chan_t ch_d;
        chan_t ch_q;

        always_comb begin
            ch_d = ch_q;
            // engine update first, so a software write to the same field wins
            if (upd_en_i && (upd_ch_i == CHW'(g))) begin
                ch_d.src = upd_src_i;
                ch_d.dst = upd_dst_i;
                ch_d.cnt = upd_cnt_i;
            end
            if (wr_en_i && (wr_ch_i == CHW'(g))) begin
                case (wr_fld_i)
                    FLD_SRC: ch_d.src = wr_data_i;
                    FLD_DST: ch_d.dst = wr_data_i;
                    FLD_CNT: ch_d.cnt = wr_data_i[CW-1:0];
                    FLD_CTL: ch_d.ctl = ctl_t'(wr_data_i[CTL_W-1:0]);
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_q <= '0;
            end else begin
                ch_q <= ch_d;
            end
        end

        assign src_o[g] = ch_q.src;
        assign dst_o[g] = ch_q.dst;
        assign cnt_o[g] = ch_q.cnt;
        assign ctl_o[g] = ch_q.ctl;
    end

endmodule

// File: rtl/ixe_seq.sv
module ixe_seq
    import ixe_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic           pick_valid_i,
    input  logic [CHW-1:0] pick_idx_i,
    input  logic [AW-1:0]  src_a_i [NCH],
    input  logic [AW-1:0]  dst_a_i [NCH],
    input  logic [CW-1:0]  cnt_a_i [NCH],
    input  ctl_t           ctl_a_i [NCH],
    input  logic           bus_grant_i,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i,
    output logic [NCH-1:0] pend_o,
    output logic [NCH-1:0] irq_o,
    output logic           stall_o,
    output logic           rd_o,
    output logic           wr_o,
    output logic           word_o,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  wdata_o,
    output logic           upd_en_o,
    output logic [CHW-1:0] upd_ch_o,
    output logic [AW-1:0]  upd_src_o,
    output logic [AW-1:0]  upd_dst_o,
    output logic [CW-1:0]  upd_cnt_o
);

    localparam int BYTE_W = 8;

    typedef struct packed {
        seq_st_e        st;
        logic [CHW-1:0] ch;
        logic [NCH-1:0] pend;
        logic [NCH-1:0] irq;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [CW-1:0]  cnt;
        ctl_t           ctl;
        logic [DW-1:0]  data;
    } seq_t;

    seq_t           q_d;
    seq_t           q_q;
    logic [NCH-1:0] clr;
    logic [AW-1:0]  step;

    always_comb begin
        q_d       = q_q;
        q_d.irq   = '0;
        clr       = '0;
        upd_en_o  = 1'b0;
        step      = q_q.ctl.word ? AW'(2) : AW'(1);
        upd_src_o = q_q.src + (q_q.ctl.src_inc ? step : '0);
        upd_dst_o = q_q.dst + (q_q.ctl.dst_inc ? step : '0);
        upd_cnt_o = q_q.ctl.cont ? q_q.cnt : q_q.cnt - CW'(1);

        case (q_q.st)
            ST_IDLE: begin
                if (pick_valid_i) begin
                    q_d.ch = pick_idx_i;
                    if (!ctl_a_i[pick_idx_i].cont && (cnt_a_i[pick_idx_i] == '0)) begin
                        // exhausted: hand back to normal interrupt, no bus use
                        clr[pick_idx_i]   = 1'b1;
                        q_d.irq[pick_idx_i] = 1'b1;
                    end else begin
                        q_d.st  = ST_GRANT;
                        q_d.src = src_a_i[pick_idx_i];
                        q_d.dst = dst_a_i[pick_idx_i];
                        q_d.cnt = cnt_a_i[pick_idx_i];
                        q_d.ctl = ctl_a_i[pick_idx_i];
                    end
                end
            end
            ST_GRANT: begin
                if (bus_grant_i) begin
                    q_d.st = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready_i) begin
                    q_d.data = q_q.ctl.word ? mem_rdata_i : DW'(mem_rdata_i[BYTE_W-1:0]);
                    q_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready_i) begin
                    upd_en_o     = 1'b1;
                    clr[q_q.ch]  = 1'b1;
                    q_d.st       = ST_IDLE;
                end
            end
            default: q_d.st = ST_IDLE;
        endcase

        // a request in the clearing cycle survives
        q_d.pend = (q_q.pend & ~clr) | req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign pend_o   = q_q.pend;
    assign irq_o    = q_q.irq;
    assign stall_o  = (q_q.st != ST_IDLE);
    assign rd_o     = (q_q.st == ST_READ);
    assign wr_o     = (q_q.st == ST_WRITE);
    assign word_o   = q_q.ctl.word;
    assign addr_o   = (q_q.st == ST_WRITE) ? q_q.dst : q_q.src;
    assign wdata_o  = q_q.data;
    assign upd_ch_o = q_q.ch;

endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
    import ixe_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic           reg_we_i,
    input  logic [CHW-1:0] reg_ch_i,
    input  logic [1:0]     reg_fld_i,
    input  logic [AW-1:0]  reg_wdata_i,
    output logic [AW-1:0]  reg_rdata_o,
    output logic           cpu_stall_o,
    input  logic           bus_grant_i,
    output logic           mem_rd_o,
    output logic           mem_wr_o,
    output logic           mem_word_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i,
    output logic [NCH-1:0] irq_o
);

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    ctl_t           ctl_a [NCH];
    logic [NCH-1:0] pend;
    logic           pick_valid;
    logic [CHW-1:0] pick_idx;
    logic           upd_en;
    logic [CHW-1:0] upd_ch;
    logic [AW-1:0]  upd_src;
    logic [AW-1:0]  upd_dst;
    logic [CW-1:0]  upd_cnt;
    fld_e           fld;

    assign fld = fld_e'(reg_fld_i);

    ixe_chan_bank #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_we_i),
        .wr_ch_i   (reg_ch_i),
        .wr_fld_i  (fld),
        .wr_data_i (reg_wdata_i),
        .upd_en_i  (upd_en),
        .upd_ch_i  (upd_ch),
        .upd_src_i (upd_src),
        .upd_dst_i (upd_dst),
        .upd_cnt_i (upd_cnt),
        .src_o     (src_a),
        .dst_o     (dst_a),
        .cnt_o     (cnt_a),
        .ctl_o     (ctl_a)
    );

    ixe_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .pend_i  (pend),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    ixe_seq #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .CHW(CHW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .pick_valid_i (pick_valid),
        .pick_idx_i   (pick_idx),
        .src_a_i      (src_a),
        .dst_a_i      (dst_a),
        .cnt_a_i      (cnt_a),
        .ctl_a_i      (ctl_a),
        .bus_grant_i  (bus_grant_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_ready_i  (mem_ready_i),
        .pend_o       (pend),
        .irq_o        (irq_o),
        .stall_o      (cpu_stall_o),
        .rd_o         (mem_rd_o),
        .wr_o         (mem_wr_o),
        .word_o       (mem_word_o),
        .addr_o       (mem_addr_o),
        .wdata_o      (mem_wdata_o),
        .upd_en_o     (upd_en),
        .upd_ch_o     (upd_ch),
        .upd_src_o    (upd_src),
        .upd_dst_o    (upd_dst),
        .upd_cnt_o    (upd_cnt)
    );

    always_comb begin
        case (fld)
            FLD_SRC: reg_rdata_o = src_a[reg_ch_i];
            FLD_DST: reg_rdata_o = dst_a[reg_ch_i];
            FLD_CNT: reg_rdata_o = AW'(cnt_a[reg_ch_i]);
            FLD_CTL: reg_rdata_o = AW'(ctl_a[reg_ch_i]);
            default: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ixe_chk.sv
module ixe_chk #(
    parameter int NCH = 8,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_stall_o,
    input logic           bus_grant_i,
    input logic           mem_rd_o,
    input logic           mem_wr_o,
    input logic           mem_ready_i,
    input logic [AW-1:0]  mem_addr_o,
    input logic [NCH-1:0] irq_o
);

    a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_o) |-> $past(mem_rd_o && mem_ready_i));

    a_r9_stall_covers_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> cpu_stall_o);

    a_r9_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_ready_i) |=> !cpu_stall_o);

    a_r9_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> $past(bus_grant_i));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    a_r7_irq_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> !cpu_stall_o);

    a_r12_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_ready_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    a_r12_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o)));

endmodule

bind irq_xfer_engine ixe_chk #(.NCH(NCH), .AW(AW)) u_ixe_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_stall_o (cpu_stall_o),
    .bus_grant_i (bus_grant_i),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .irq_o       (irq_o)
);

// File: tb/irq_xfer_engine_tb.sv
module irq_xfer_engine_tb;

    localparam int NCH = 8;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int CHW = 3;

    localparam logic [1:0] F_SRC = 2'd0;
    localparam logic [1:0] F_DST = 2'd1;
    localparam logic [1:0] F_CNT = 2'd2;
    localparam logic [1:0] F_CTL = 2'd3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] req_i;
    logic           reg_we_i;
    logic [CHW-1:0] reg_ch_i;
    logic [1:0]     reg_fld_i;
    logic [AW-1:0]  reg_wdata_i;
    logic [AW-1:0]  reg_rdata_o;
    logic           cpu_stall_o;
    logic           bus_grant_i;
    logic           mem_rd_o;
    logic           mem_wr_o;
    logic           mem_word_o;
    logic [AW-1:0]  mem_addr_o;
    logic [DW-1:0]  mem_wdata_o;
    logic [DW-1:0]  mem_rdata_i;
    logic           mem_ready_i;
    logic [NCH-1:0] irq_o;

    always #2 clk = ~clk;

    irq_xfer_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

    function automatic logic [15:0] memval(input logic [15:0] a);
        return a ^ 16'hC35A;
    endfunction

    assign mem_rdata_i = memval(mem_addr_o);

    int  checks = 0;
    int  errors = 0;
    int  cyc    = 0;
    bit  fast   = 1'b0;
    bit  done   = 1'b0;

    typedef struct {
        int          ch;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] data;
        bit          word;
        string       tag;
    } xf_t;

    xf_t exp_q[$];
    int  irq_q[$];

    logic [15:0] m_src [NCH];
    logic [15:0] m_dst [NCH];
    logic [7:0]  m_cnt [NCH];
    logic [3:0]  m_ctl [NCH];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // requirement model of one service: copy or exhaustion pulse
    task automatic model_service(input int ch, input string tag);
        xf_t         e;
        logic [15:0] v;
        logic [15:0] st;
        if (!m_ctl[ch][3] && (m_cnt[ch] == 8'd0)) begin
            irq_q.push_back(ch);
        end else begin
            v      = memval(m_src[ch]);
            e.ch   = ch;
            e.src  = m_src[ch];
            e.dst  = m_dst[ch];
            e.word = m_ctl[ch][0];
            e.data = e.word ? v : {8'h00, v[7:0]};
            e.tag  = tag;
            exp_q.push_back(e);
            st = m_ctl[ch][0] ? 16'd2 : 16'd1;
            if (m_ctl[ch][1]) m_src[ch] = m_src[ch] + st;
            if (m_ctl[ch][2]) m_dst[ch] = m_dst[ch] + st;
            if (!m_ctl[ch][3]) m_cnt[ch] = m_cnt[ch] - 8'd1;
        end
    endtask

    // bus model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        mem_ready_i = fast ? 1'b1 : ((cyc % 3) != 0);
        bus_grant_i = cpu_stall_o && (fast || ((cyc % 4) == 0));
        #1;
        if (rst_n) begin
            if (mem_rd_o && mem_ready_i) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R4", "unexpected read", 32'(mem_addr_o), 32'h0);
                else
                    chk(mem_addr_o == exp_q[0].src, exp_q[0].tag, "read address",
                        32'(mem_addr_o), 32'(exp_q[0].src));
            end
            if (mem_wr_o && mem_ready_i) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write", 32'(mem_addr_o), 32'h0);
                end else begin
                    xf_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr_o == e.dst, e.tag, "write address", 32'(mem_addr_o), 32'(e.dst));
                    chk(mem_wdata_o == e.data, e.tag, "write data", 32'(mem_wdata_o), 32'(e.data));
                    chk(mem_word_o == e.word, "R4", "size", 32'(mem_word_o), 32'(e.word));
                end
            end
            if (|irq_o) begin
                if (irq_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected pulse", 32'(irq_o), 32'h0);
                end else begin
                    int c;
                    c = irq_q.pop_front();
                    chk(irq_o == NCH'(1 << c), "R7", "pulse channel", 32'(irq_o), 32'(1 << c));
                end
            end
        end
    end

    task automatic reg_write(input int ch, input logic [1:0] f, input logic [15:0] v);
        @(negedge clk);
        reg_we_i    = 1'b1;
        reg_ch_i    = CHW'(ch);
        reg_fld_i   = f;
        reg_wdata_i = v;
        @(negedge clk);
        reg_we_i    = 1'b0;
        case (f)
            F_SRC: m_src[ch] = v;
            F_DST: m_dst[ch] = v;
            F_CNT: m_cnt[ch] = v[7:0];
            default: m_ctl[ch] = v[3:0];
        endcase
    endtask

    task automatic reg_check(input int ch, input logic [1:0] f, input logic [15:0] exp,
                             input string req);
        @(negedge clk);
        reg_ch_i  = CHW'(ch);
        reg_fld_i = f;
        #1;
        chk(reg_rdata_o == exp, req, $sformatf("readback ch%0d field%0d", ch, f),
            32'(reg_rdata_o), 32'(exp));
    endtask

    task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                         input logic [7:0] n, input logic [3:0] c);
        reg_write(ch, F_SRC, s);
        reg_write(ch, F_DST, d);
        reg_write(ch, F_CNT, {8'h00, n});
        reg_write(ch, F_CTL, {12'h000, c});
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #1;
            if (exp_q.size() == 0 && irq_q.size() == 0 && !cpu_stall_o) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic fire(input logic [NCH-1:0] mask, input string tag);
        @(negedge clk);
        req_i = mask;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) model_service(c, tag);
        end
        @(negedge clk);
        req_i = '0;
        wait_idle();
    endtask

    // drive a second event in the very cycle the write phase completes
    task automatic fire_collide(input int ch, input bit reg_hit);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        req_i = NCH'(1 << ch);
        model_service(ch, reg_hit ? "R11" : "R10");
        @(negedge clk);
        req_i = '0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (mem_wr_o && mem_ready_i) seen = 1'b1;
        end
        chk(seen, "R9", "write phase seen", 32'(seen), 32'h1);
        chk(cpu_stall_o == 1'b1, "R9", "stall held at write accept", 32'(cpu_stall_o), 32'h1);
        if (reg_hit) begin
            reg_we_i    = 1'b1;
            reg_ch_i    = CHW'(ch);
            reg_fld_i   = F_SRC;
            reg_wdata_i = 16'h7777;
            m_src[ch]   = 16'h7777;
        end else begin
            req_i = NCH'(1 << ch);
            model_service(ch, "R10");
        end
        @(negedge clk);
        req_i    = '0;
        reg_we_i = 1'b0;
        #1;
        chk(cpu_stall_o == 1'b0 || !reg_hit, "R9", "stall released after write",
            32'(cpu_stall_o), 32'h0);
        wait_idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        req_i       = '0;
        reg_we_i    = 1'b0;
        reg_ch_i    = '0;
        reg_fld_i   = '0;
        reg_wdata_i = '0;
        mem_ready_i = 1'b0;
        bus_grant_i = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0; m_ctl[c] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!cpu_stall_o && !mem_rd_o && !mem_wr_o, "R1", "bus idle after reset",
            {29'h0, cpu_stall_o, mem_rd_o, mem_wr_o}, 32'h0);
        chk(irq_o == '0, "R1", "no pulse after reset", 32'(irq_o), 32'h0);
        reg_check(3, F_SRC, 16'h0000, "R1");
        reg_check(3, F_CTL, 16'h0000, "R1");
        repeat (4) @(negedge clk);
        #1;
        chk(!cpu_stall_o, "R1", "no pending request after reset", 32'(cpu_stall_o), 32'h0);

        // R2, R3: program and read back; word, both pointers advance
        setup(0, 16'h1000, 16'h2000, 8'd3, 4'b0111);
        reg_check(0, F_SRC, 16'h1000, "R2");
        reg_check(0, F_DST, 16'h2000, "R2");
        reg_check(0, F_CNT, 16'h0003, "R2");
        reg_check(0, F_CTL, 16'h0007, "R3");
        for (int k = 0; k < 3; k++) fire(8'h01, "R4");
        reg_check(0, F_SRC, 16'h1006, "R5");
        reg_check(0, F_DST, 16'h2006, "R5");
        reg_check(0, F_CNT, 16'h0000, "R6");
        fire(8'h01, "R7");
        reg_check(0, F_SRC, 16'h1006, "R7");
        reg_check(0, F_DST, 16'h2006, "R7");

        // byte size, source advance only
        setup(1, 16'h0301, 16'h0400, 8'd2, 4'b0010);
        fire(8'h02, "R4");
        fire(8'h02, "R4");
        reg_check(1, F_SRC, 16'h0303, "R5");
        reg_check(1, F_DST, 16'h0400, "R5");

        // continuous: count zero but copies continue, count unchanged
        setup(2, 16'h0500, 16'h0600, 8'd0, 4'b1101);
        for (int k = 0; k < 3; k++) fire(8'h04, "R6");
        reg_check(2, F_CNT, 16'h0000, "R6");
        reg_check(2, F_DST, 16'h0606, "R6");

        // simultaneous requests, mixed exhausted and active channels
        setup(4, 16'h4000, 16'h4800, 8'd1, 4'b0111);
        setup(5, 16'h5000, 16'h5800, 8'd0, 4'b0000);
        setup(6, 16'h6000, 16'h6800, 8'd4, 4'b0111);
        setup(7, 16'h7000, 16'h7800, 8'd2, 4'b0111);
        fire(8'hF6, "R8");
        reg_check(5, F_SRC, 16'h5000, "R7");
        reg_check(4, F_CNT, 16'h0000, "R8");

        // same-cycle events at completion, fast bus
        fast = 1'b1;
        fire_collide(6, 1'b0);
        reg_check(6, F_CNT, 16'h0001, "R10");
        reg_check(6, F_SRC, 16'h6006, "R10");
        fire_collide(7, 1'b1);
        reg_check(7, F_SRC, 16'h7777, "R11");
        reg_check(7, F_DST, 16'h7804, "R11");
        reg_check(7, F_CNT, 16'h0000, "R11");

        chk(exp_q.size() == 0, "R4", "all copies seen", 32'(exp_q.size()), 32'h0);
        chk(irq_q.size() == 0, "R7", "all pulses seen", 32'(irq_q.size()), 32'h0);
        finish_run();
    end

endmodule